// File: doc/BRIEF.md
# Binary strip stub finder

The block takes two layers of binary strip hits, one word of comparator bits per layer, every bunch crossing. For each crossing it reports whether the two layers line up into short track segments, called stubs. Each layer has 127 channels. A per-channel blocking mask removes noisy channels first. Runs of adjacent hits are then grouped into clusters, and any cluster wider than a configurable limit is thrown away. Each surviving cluster is placed on a half-strip grid.

Every accepted cluster in the lower layer acts as a seed. The block looks for an accepted upper-layer cluster within a configurable window around the seed. When it finds one, it forms a stub. The stub carries the seed's half-strip address and a signed bend, which is the upper position minus the lower position. Up to three stubs are reported each crossing, with a one-bit trigger flag and an overflow flag. All configuration arrives on plain input ports, and results come out two clock cycles after the hits.

Top module: `strip_stub_finder`

## Requirements
- R1: A channel whose mask bit is 1 counts as not hit. Bit n of `lower_mask_i` or `upper_mask_i` blocks channel n of that layer, and bit n of a hit word is channel n.
- R2: A cluster is a maximal run of adjacent hit channels. It is accepted only if its width in channels is at most `max_width_i` (1, 2 or 3; 0 accepts nothing). The same cut applies to both layers.
- R3: A cluster of width 1 or 3 centred on channel n has position 2n. A cluster of width 2 on channels n and n+1 has position 2n+1.
- R4: Take a lower cluster at position L and an upper cluster at position U. They form a stub when |U-L| <= `window_i` (0 to 15). The stub address is L (8 bits) and the bend is U-L as a 5-bit two's complement value.
- R5: When several upper clusters lie in the window, the one with the smallest |U-L| is used. Between equal distances, the negative offset wins.
- R6: `trig_o` is 1 in a crossing exactly when at least one stub was found.
- R7: Slot k sits in `stub_addr_o[8k+7:8k]` and `stub_bend_o[5k+4:5k]`, with valid bit `stub_valid_o[k]`. Slots fill from slot 0 in ascending address order. Unused slots read valid 0 with zero fields. When more than three stubs exist, the three lowest addresses are reported and `overflow_o` is 1.
- R8: All inputs, including configuration, are taken at the same rising edge k. The result appears at the outputs after edge k+1, and not after edge k.
- R9: While `rst_ni` is low, every output is 0.
- R10: Channels beyond 0 and 126 count as empty. Clusters touching either end are found and positioned normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Crossing clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lower_hits_i | input | 127 | Lower-layer comparator bits |
| upper_hits_i | input | 127 | Upper-layer comparator bits |
| lower_mask_i | input | 127 | Lower-layer blocking mask |
| upper_mask_i | input | 127 | Upper-layer blocking mask |
| max_width_i | input | 2 | Widest accepted cluster |
| window_i | input | 4 | Correlation half-width in half strips |
| trig_o | output | 1 | At least one stub this crossing |
| stub_valid_o | output | 3 | Slot valid bits |
| stub_addr_o | output | 24 | Packed slot addresses |
| stub_bend_o | output | 15 | Packed slot bends |
| overflow_o | output | 1 | More than three stubs existed |

## Verification
The pipeline holds only two register stages and no history, so any wrong internal state shows at the ports within two cycles of the frame that exposes it. A bad stage-one register or mask shows up as a missing or extra stub on the very next output word. A fault in clustering, the window search or slot selection shows up as a wrong address, a wrong bend sign or magnitude, or slots out of order in that same word. The directed frames place clusters at the window limit, at equal distances on both sides of a seed, at both chip ends and in numbers above three, so that each such fault changes a specific field.

// File: rtl/stub_pkg.sv
`timescale 1ns/1ps
package stub_pkg;
  localparam int unsigned NUM_CH  = 127;
  localparam int unsigned POS_W   = 8;
  localparam int unsigned BEND_W  = 5;
  localparam int unsigned WIN_W   = 4;
  localparam int unsigned WIDTH_W = 2;
  localparam int unsigned N_SLOT  = 3;
endpackage

// File: rtl/stub_cluster_finder.sv
`timescale 1ns/1ps
module stub_cluster_finder #(
  parameter int unsigned NCH   = stub_pkg::NUM_CH,
  parameter int unsigned WID_W = stub_pkg::WIDTH_W,
  localparam int unsigned NPOS = 2*NCH-1
) (
  input  logic [NCH-1:0]   hits_i,
  input  logic [WID_W-1:0] max_width_i,
  output logic [NPOS-1:0]  pos_map_o
);
  localparam int unsigned PAD = NCH + 4;

  // padded[c+1] holds channel c; both ends are empty
  logic [PAD-1:0] padded;
  logic [NCH-1:0] run_start, is_w1, is_w2, is_w3;
  logic           ok_w1, ok_w2, ok_w3;

  always_comb begin
    padded        = '0;
    padded[NCH:1] = hits_i;
  end

  assign ok_w1 = (max_width_i >= WID_W'(1));
  assign ok_w2 = (max_width_i >= WID_W'(2));
  assign ok_w3 = (max_width_i >= WID_W'(3));

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    assign run_start[i] = padded[i+1] & ~padded[i];
    assign is_w1[i] = run_start[i] & ~padded[i+2];
    assign is_w2[i] = run_start[i] &  padded[i+2] & ~padded[i+3];
    assign is_w3[i] = run_start[i] &  padded[i+2] &  padded[i+3] & ~padded[i+4];
  end

  for (genvar p = 0; p < NPOS; p++) begin : g_pos
    if (p % 2 == 1) begin : g_odd
      assign pos_map_o[p] = is_w2[p/2] & ok_w2;
    end else if (p == 0) begin : g_first
      assign pos_map_o[p] = is_w1[0] & ok_w1;
    end else begin : g_even
      assign pos_map_o[p] = (is_w1[p/2] & ok_w1) | (is_w3[p/2-1] & ok_w3);
    end
  end
endmodule

// File: rtl/stub_correlator.sv
`timescale 1ns/1ps
module stub_correlator #(
  parameter int unsigned NPOS   = 2*stub_pkg::NUM_CH-1,
  parameter int unsigned BEND_W = stub_pkg::BEND_W,
  parameter int unsigned WIN_W  = stub_pkg::WIN_W
) (
  input  logic [NPOS-1:0]              lo_map_i,
  input  logic [NPOS-1:0]              up_map_i,
  input  logic [WIN_W-1:0]             window_i,
  output logic [NPOS-1:0]              match_o,
  output logic [NPOS-1:0][BEND_W-1:0]  bend_o
);
  localparam int unsigned KMAX = (1 << WIN_W) - 1;
  localparam int unsigned UPW  = NPOS + 2*KMAX;

  logic [UPW-1:0] up_pad;

  always_comb begin
    up_pad                = '0;
    up_pad[KMAX +: NPOS]  = up_map_i;
  end

  for (genvar p = 0; p < NPOS; p++) begin : g_seed
    always_comb begin
      logic              found;
      logic [BEND_W-1:0] off;
      found = 1'b0;
      off   = '0;
      // nearest distance first, negative side before positive
      for (int k = 0; k <= int'(KMAX); k++) begin
        if (!found && (k <= int'(window_i))) begin
          if (up_pad[p + int'(KMAX) - k]) begin
            found = 1'b1;
            off   = BEND_W'(-k);
          end else if (up_pad[p + int'(KMAX) + k]) begin
            found = 1'b1;
            off   = BEND_W'(k);
          end
        end
      end
      match_o[p] = lo_map_i[p] & found;
      bend_o[p]  = (lo_map_i[p] & found) ? off : '0;
    end
  end
endmodule

// File: rtl/stub_selector.sv
`timescale 1ns/1ps
module stub_selector #(
  parameter int unsigned NPOS   = 2*stub_pkg::NUM_CH-1,
  parameter int unsigned POS_W  = stub_pkg::POS_W,
  parameter int unsigned BEND_W = stub_pkg::BEND_W,
  parameter int unsigned NSTUB  = stub_pkg::N_SLOT
) (
  input  logic [NPOS-1:0]               match_i,
  input  logic [NPOS-1:0][BEND_W-1:0]   bend_i,
  output logic [NSTUB-1:0]              valid_o,
  output logic [NSTUB-1:0][POS_W-1:0]   addr_o,
  output logic [NSTUB-1:0][BEND_W-1:0]  bend_o,
  output logic                          ovf_o
);
  always_comb begin
    int cnt;
    cnt     = 0;
    valid_o = '0;
    addr_o  = '0;
    bend_o  = '0;
    // ascending scan keeps the lowest addresses
    for (int p = 0; p < int'(NPOS); p++) begin
      if (match_i[p]) begin
        if (cnt < int'(NSTUB)) begin
          valid_o[cnt] = 1'b1;
          addr_o[cnt]  = POS_W'(p);
          bend_o[cnt]  = bend_i[p];
        end
        cnt = cnt + 1;
      end
    end
    ovf_o = (cnt > int'(NSTUB));
  end
endmodule

// File: rtl/strip_stub_finder.sv
`timescale 1ns/1ps
module strip_stub_finder #(
  parameter int unsigned NCH    = stub_pkg::NUM_CH,
  parameter int unsigned POS_W  = stub_pkg::POS_W,
  parameter int unsigned BEND_W = stub_pkg::BEND_W,
  parameter int unsigned WIN_W  = stub_pkg::WIN_W,
  parameter int unsigned WID_W  = stub_pkg::WIDTH_W,
  parameter int unsigned NSTUB  = stub_pkg::N_SLOT
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NCH-1:0]            lower_hits_i,
  input  logic [NCH-1:0]            upper_hits_i,
  input  logic [NCH-1:0]            lower_mask_i,
  input  logic [NCH-1:0]            upper_mask_i,
  input  logic [WID_W-1:0]          max_width_i,
  input  logic [WIN_W-1:0]          window_i,
  output logic                      trig_o,
  output logic [NSTUB-1:0]          stub_valid_o,
  output logic [NSTUB*POS_W-1:0]    stub_addr_o,
  output logic [NSTUB*BEND_W-1:0]   stub_bend_o,
  output logic                      overflow_o
);
  localparam int unsigned NPOS = 2*NCH-1;

  // stage 1: masked hits and configuration
  logic [NCH-1:0]   lo_d, lo_q, up_d, up_q;
  logic [WID_W-1:0] wid_d, wid_q;
  logic [WIN_W-1:0] win_d, win_q;

  always_comb begin
    lo_d  = lower_hits_i & ~lower_mask_i;
    up_d  = upper_hits_i & ~upper_mask_i;
    wid_d = max_width_i;
    win_d = window_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q  <= '0;
      up_q  <= '0;
      wid_q <= '0;
      win_q <= '0;
    end else begin
      lo_q  <= lo_d;
      up_q  <= up_d;
      wid_q <= wid_d;
      win_q <= win_d;
    end
  end

  // stage 2: clustering, correlation, slot selection
  logic [NPOS-1:0]             lo_map, up_map, match;
  logic [NPOS-1:0][BEND_W-1:0] pos_bend;
  logic [NSTUB-1:0]            sel_valid;
  logic [NSTUB-1:0][POS_W-1:0] sel_addr;
  logic [NSTUB-1:0][BEND_W-1:0] sel_bend;
  logic                        sel_ovf;

  stub_cluster_finder #(.NCH(NCH), .WID_W(WID_W)) i_lo_clu (
    .hits_i(lo_q), .max_width_i(wid_q), .pos_map_o(lo_map)
  );

  stub_cluster_finder #(.NCH(NCH), .WID_W(WID_W)) i_up_clu (
    .hits_i(up_q), .max_width_i(wid_q), .pos_map_o(up_map)
  );

  stub_correlator #(.NPOS(NPOS), .BEND_W(BEND_W), .WIN_W(WIN_W)) i_corr (
    .lo_map_i(lo_map), .up_map_i(up_map), .window_i(win_q),
    .match_o(match), .bend_o(pos_bend)
  );

  stub_selector #(.NPOS(NPOS), .POS_W(POS_W), .BEND_W(BEND_W), .NSTUB(NSTUB)) i_sel (
    .match_i(match), .bend_i(pos_bend), .valid_o(sel_valid),
    .addr_o(sel_addr), .bend_o(sel_bend), .ovf_o(sel_ovf)
  );

  logic                          trig_d, trig_q, ovf_q;
  logic [NSTUB-1:0]              valid_q;
  logic [NSTUB*POS_W-1:0]        addr_d, addr_q;
  logic [NSTUB*BEND_W-1:0]       bend_d, bend_q;

  assign trig_d = |match;

  for (genvar s = 0; s < NSTUB; s++) begin : g_pack
    assign addr_d[s*POS_W  +: POS_W]  = sel_addr[s];
    assign bend_d[s*BEND_W +: BEND_W] = sel_bend[s];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_q  <= 1'b0;
      ovf_q   <= 1'b0;
      valid_q <= '0;
      addr_q  <= '0;
      bend_q  <= '0;
    end else begin
      trig_q  <= trig_d;
      ovf_q   <= sel_ovf;
      valid_q <= sel_valid;
      addr_q  <= addr_d;
      bend_q  <= bend_d;
    end
  end

  assign trig_o       = trig_q;
  assign overflow_o   = ovf_q;
  assign stub_valid_o = valid_q;
  assign stub_addr_o  = addr_q;
  assign stub_bend_o  = bend_q;

  // checks
  logic signed [BEND_W-1:0] chk_b0;
  logic        [BEND_W-1:0] chk_mag0;
  assign chk_b0   = stub_bend_o[BEND_W-1:0];
  assign chk_mag0 = (chk_b0 < 0) ? BEND_W'(-chk_b0) : BEND_W'(chk_b0);

  AST_TRIG_IFF_SLOT0: assert property (@(posedge clk_i) disable iff (!rst_ni) trig_o == stub_valid_o[0]); // R6
  AST_OVF_ALL_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni) overflow_o |-> (&stub_valid_o)); // R7
  AST_SLOT1_PACKED: assert property (@(posedge clk_i) disable iff (!rst_ni) stub_valid_o[1] |-> stub_valid_o[0]); // R7
  AST_SLOT2_PACKED: assert property (@(posedge clk_i) disable iff (!rst_ni) stub_valid_o[2] |-> stub_valid_o[1]); // R7
  AST_ADDR_ASCEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stub_valid_o[1] |-> (stub_addr_o[POS_W-1:0] < stub_addr_o[2*POS_W-1:POS_W])); // R7
  AST_BEND_IN_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stub_valid_o[0] |-> ({1'b0, chk_mag0} <= (BEND_W+1)'($past(win_q)))); // R4
  AST_SEED_TWO_AGO: assert property (@(posedge clk_i) disable iff (!rst_ni) trig_o |-> $past(|lo_q)); // R8
endmodule

// File: tb/test_strip_stub_finder.sv
`timescale 1ns/1ps
module test_strip_stub_finder;
  logic         clk = 1'b0;
  logic         rst_n;
  logic [126:0] lo_h, up_h, lo_m, up_m;
  logic [1:0]   max_w;
  logic [3:0]   win;
  logic         trig, ovf;
  logic [2:0]   valid;
  logic [23:0]  addr;
  logic [14:0]  bend;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  strip_stub_finder i_strip_stub_finder (
    .clk_i(clk), .rst_ni(rst_n),
    .lower_hits_i(lo_h), .upper_hits_i(up_h),
    .lower_mask_i(lo_m), .upper_mask_i(up_m),
    .max_width_i(max_w), .window_i(win),
    .trig_o(trig), .stub_valid_o(valid), .stub_addr_o(addr),
    .stub_bend_o(bend), .overflow_o(ovf)
  );

  function automatic logic [126:0] chs(input int a, input int b = -1, input int c = -1,
                                       input int d = -1, input int e = -1);
    logic [126:0] r;
    r = '0;
    if (a >= 0) r[a] = 1'b1;
    if (b >= 0) r[b] = 1'b1;
    if (c >= 0) r[c] = 1'b1;
    if (d >= 0) r[d] = 1'b1;
    if (e >= 0) r[e] = 1'b1;
    return r;
  endfunction

  task automatic check_val(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic expect_out(input string req, input int e_trig, input int e_valid,
                            input int a0, input int b0, input int a1, input int b1,
                            input int a2, input int b2, input int e_ovf);
    check_val(req, "trig",  int'(trig), e_trig);
    check_val(req, "valid", int'(valid), e_valid);
    check_val(req, "addr0", int'(addr[7:0]),   a0);
    check_val(req, "addr1", int'(addr[15:8]),  a1);
    check_val(req, "addr2", int'(addr[23:16]), a2);
    check_val(req, "bend0", int'(bend[4:0]),   b0 & 31);
    check_val(req, "bend1", int'(bend[9:5]),   b1 & 31);
    check_val(req, "bend2", int'(bend[14:10]), b2 & 31);
    check_val(req, "overflow", int'(ovf), e_ovf);
  endtask

  task automatic expect_none(input string req);
    expect_out(req, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  // drive one crossing, wait two edges, sample mid-cycle
  task automatic frame(input logic [126:0] lo, input logic [126:0] up);
    @(negedge clk);
    lo_h = lo;
    up_h = up;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    lo_h = chs(5); up_h = chs(5); lo_m = '0; up_m = '0;
    max_w = 2'd3; win = 4'd5;
    repeat (3) @(posedge clk);
    @(negedge clk);
    expect_none("R9 reset");
    rst_n = 1'b1;
  endtask

  task automatic t_single_latency();
    frame('0, '0);
    @(negedge clk);
    lo_h = chs(10); up_h = chs(12);
    @(posedge clk);
    #1;
    check_val("R8 one edge", "trig", int'(trig), 0);
    @(posedge clk);
    @(negedge clk);
    expect_out("R8 R4 single", 1, 1, 20, 4, 0, 0, 0, 0, 0);
  endtask

  task automatic t_positions();
    frame(chs(30, 31, 50, 51, 52), chs(30, 51));
    expect_out("R3 widths", 1, 3, 61, -1, 102, 0, 0, 0, 0);
  endtask

  task automatic t_width_cut();
    max_w = 2'd2;
    frame(chs(50, 51, 52, 70), chs(51, 70));
    expect_out("R2 lower wide", 1, 1, 140, 0, 0, 0, 0, 0, 0);
    frame(chs(80), chs(79, 80, 81));
    expect_none("R2 upper wide");
    max_w = 2'd1;
    frame(chs(30, 31), chs(30));
    expect_none("R2 width one");
    max_w = 2'd0;
    frame(chs(10), chs(10));
    expect_none("R2 width zero");
    max_w = 2'd3;
  endtask

  task automatic t_window();
    win = 4'd5;
    frame(chs(20), chs(23));
    expect_none("R4 outside");
    frame(chs(20), chs(22, 23));
    expect_out("R4 at limit", 1, 1, 40, 5, 0, 0, 0, 0, 0);
    win = 4'd4;
    frame(chs(20), chs(22, 23));
    expect_none("R4 past limit");
    win = 4'd15;
    frame(chs(20), chs(27));
    expect_out("R4 wide plus", 1, 1, 40, 14, 0, 0, 0, 0, 0);
    frame(chs(40), chs(33));
    expect_out("R4 wide minus", 1, 1, 80, -14, 0, 0, 0, 0, 0);
    frame(chs(20), chs(28));
    expect_none("R4 beyond max");
    win = 4'd0;
    frame(chs(10), chs(10));
    expect_out("R4 zero window", 1, 1, 20, 0, 0, 0, 0, 0, 0);
    frame(chs(10), chs(11));
    expect_none("R4 zero miss");
    win = 4'd5;
  endtask

  task automatic t_closest();
    frame(chs(60, 100), chs(59, 61, 98, 101));
    expect_out("R5 tie and nearest", 1, 3, 120, -2, 200, 2, 0, 0, 0);
  endtask

  task automatic t_overflow();
    frame(chs(10, 20, 30, 40, 50), chs(10, 20, 30, 40, 50));
    expect_out("R7 R6 overflow", 1, 7, 20, 0, 40, 0, 60, 0, 1);
    frame(chs(10, 20, 30), chs(10, 20, 30));
    expect_out("R7 exactly three", 1, 7, 20, 0, 40, 0, 60, 0, 0);
  endtask

  task automatic t_mask();
    lo_m = chs(10);
    frame(chs(10), chs(10));
    expect_none("R1 lower mask");
    lo_m = '0; up_m = chs(10);
    frame(chs(10), chs(10));
    expect_none("R1 upper mask");
    up_m = '0; lo_m = chs(31);
    frame(chs(30, 31, 32), chs(30, 32));
    expect_out("R1 split cluster", 1, 3, 60, 0, 64, 0, 0, 0, 0);
    lo_m = '0;
  endtask

  task automatic t_edges();
    frame(chs(0, 125, 126), chs(0, 126));
    expect_out("R10 chip ends", 1, 3, 0, 0, 251, 1, 0, 0, 0);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #500000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    t_reset();
    t_single_latency();
    t_positions();
    t_width_cut();
    t_window();
    t_closest();
    t_overflow();
    t_mask();
    t_edges();
    report();
  end
endmodule